// File: doc/BRIEF.md
# Sigma-Delta ADC Bring-Up Sequencer

This block is an SPI master that takes an external sigma-delta converter from power-on to a calibrated, idle state without software help. A single `start` pulse begins the sequence. The block first puts the converter's serial port into a known state and waits for it to settle. It then reads the identity register and checks it. Next it programs the operating mode, the input configuration and, if enabled, the excitation current outputs. Last, it runs an internal zero-scale and full-scale calibration on each differential input. Each calibration step ends when the converter pulls its shared data-out line low, and that line is also the ready flag.

All SPI traffic uses mode 3: SCLK idles high, data changes on the falling edge and is sampled on the rising edge, and the most significant bit goes first. Chip select stays low across a command byte and its data bytes. Every register access starts with a command byte laid out as {0, read, addr[2:0], 0, 0, 0}. The register addresses are fixed: mode = 1, configuration = 2, identity = 4, excitation = 5. When the sequence succeeds, `done` pulses for one cycle. When the identity does not match or a calibration never finishes, `err` is raised and holds until the next start.

Top module: `sdadc_bringup_seq`

## Requirements
- R1: The first frame after `start` is 32 SCLK cycles inside one chip-select-low window, with MOSI held at 1 for all of them.
- R2: At least SETTLE_CYCLES clock cycles pass between the end of the reset frame and the start of the next frame.
- R3: Every register access frame begins with a command byte. Bit 7 of that byte is 0, bit 6 is 1 for a read, bits 5:3 hold the address, and bits 2:0 are 0.
- R4: The identity read is a 16-bit frame with command 0x60. Only the low 4 bits of the returned byte are compared with `exp_id`, and the upper 4 bits are ignored. On a mismatch, `err` is raised and no further frame is sent.
- R5: The mode register is written as 24 bits: command 0x08, then a 16-bit word with bits 15:13 = 2 (idle), bits 7:6 = `clk_sel`, bits 3:0 = 1, and all other bits 0.
- R6: The configuration register is written as 24 bits: command 0x10, then a 16-bit word with bits 10:8 = `gain_sel`, bit 4 = `buf_on`, bits 3:0 = channel, and all other bits 0. The first configuration write uses channel 0.
- R7: When `exc_on` is 1, a 16-bit frame follows: command 0x28, then a byte with bits 3:2 = `exc_route` and bits 1:0 = `exc_mag`. When `exc_on` is 0, this frame is not sent.
- R8: For channel 0, then 1, then 2, the block sends three frames: a configuration write selecting that channel, a mode write with bits 15:13 = 4, and a mode write with bits 15:13 = 5. Each of the two mode writes waits for a high-to-low transition on MISO before the next frame.
- R9: If MISO does not fall within CAL_TIMEOUT cycles after a calibration mode write, `err` is raised and no further frame is sent.
- R10: On success, `done` is high for exactly one cycle and `busy` falls at the same edge. `done` and `err` are never high together, and `busy` only falls together with one of them.
- R11: A `start` pulse while `busy` is high has no effect. The frame count and the number of `done` pulses are those of a single run.
- R12: SCLK idles high and toggles only while `cs_n` is low. MOSI changes while SCLK is low and is valid on each rising edge.
- R13: `err` stays high after a failure until the next `start`, and a later successful run ends with `err` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a bring-up run when idle |
| exp_id | input | 4 | Expected low nibble of the identity register |
| clk_sel | input | 2 | Converter clock-source field for the mode word |
| gain_sel | input | 3 | Gain field for the configuration word |
| buf_on | input | 1 | Input buffer enable for the configuration word |
| exc_on | input | 1 | Enables the excitation-current register write |
| exc_mag | input | 2 | Excitation current magnitude code |
| exc_route | input | 2 | Excitation current routing code |
| miso | input | 1 | Serial data from the converter; low also means ready |
| sclk | output | 1 | SPI clock, idles high |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to the converter |
| done | output | 1 | One-cycle pulse on successful completion |
| busy | output | 1 | High while a sequence is in progress |
| err | output | 1 | Held high after an identity mismatch or calibration timeout |

## Verification
The hardest case to reach from the ports is a calibration timeout partway through the run, after several earlier ready handshakes have already succeeded. At that point the sequencer has to give up on exactly one waiting step and send nothing more. The bench's converter model gives a fixed budget of ready responses per run, each a rising then falling MISO level a fixed delay after a calibration mode write. Once the budget is spent, the model holds MISO high, so the run can stall at a chosen step. The identity mismatch is driven from the same model through the byte it shifts out, and that byte carries a non-zero upper nibble in a passing run.

// File: rtl/sdadc_seq_pkg.sv
package sdadc_seq_pkg;

  // converter register addresses (bits 5:3 of the command byte)
  localparam logic [2:0] REG_MODE = 3'd1;
  localparam logic [2:0] REG_CONF = 3'd2;
  localparam logic [2:0] REG_ID   = 3'd4;
  localparam logic [2:0] REG_IO   = 3'd5;

  // operating-mode codes for mode word bits 15:13
  localparam logic [2:0] OPM_IDLE     = 3'd2;
  localparam logic [2:0] OPM_ZERO_CAL = 3'd4;
  localparam logic [2:0] OPM_FULL_CAL = 3'd5;

  localparam logic [3:0] RATE_BOOT = 4'd1;

  typedef enum logic [3:0] {
    S_IDLE,
    S_RST,
    S_SETTLE,
    S_ID,
    S_MODE,
    S_CONF,
    S_IO,
    S_SEL,
    S_CAL,
    S_CAL_WAIT,
    S_FAIL
  } seq_state_e;

  function automatic logic [7:0] cmd_byte(input logic rd, input logic [2:0] addr);
    return {1'b0, rd, addr, 3'b000};
  endfunction

  function automatic logic [15:0] mode_word(input logic [2:0] opm,
                                            input logic [1:0] clk_src,
                                            input logic [3:0] rate);
    return {opm, 5'b0, clk_src, 2'b0, rate};
  endfunction

  function automatic logic [15:0] conf_word(input logic [2:0] gain,
                                            input logic       buf_en,
                                            input logic [3:0] chan);
    return {5'b0, gain, 3'b0, buf_en, chan};
  endfunction

  function automatic logic [7:0] io_byte(input logic [1:0] mag, input logic [1:0] route);
    return {4'b0, route, mag};
  endfunction

endpackage

// File: rtl/sdadc_spi_shifter.sv
module sdadc_spi_shifter #(
  parameter int unsigned CLK_DIV = 4,
  parameter int unsigned FRAME_W = 32,
  parameter int unsigned RX_W    = 4,
  localparam int unsigned LEN_W  = $clog2(FRAME_W + 1),
  localparam int unsigned DIV_W  = $clog2(CLK_DIV + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go,
  input  logic [LEN_W-1:0]   len,
  input  logic [FRAME_W-1:0] tx,
  input  logic               miso,
  output logic [RX_W-1:0]    rx,
  output logic               fin,
  output logic               sclk,
  output logic               cs_n,
  output logic               mosi
);

  localparam logic [DIV_W-1:0] DIV_INIT = DIV_W'(CLK_DIV - 1);

  logic               active;
  logic               first;
  logic               sclk_q;
  logic               cs_q;
  logic               fin_q;
  logic [FRAME_W-1:0] sh;
  logic [RX_W-1:0]    rx_q;
  logic [LEN_W-1:0]   left;
  logic [DIV_W-1:0]   div;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      first  <= 1'b0;
      sclk_q <= 1'b1;
      cs_q   <= 1'b1;
      fin_q  <= 1'b0;
      sh     <= '0;
      rx_q   <= '0;
      left   <= '0;
      div    <= '0;
    end else begin
      fin_q <= 1'b0;
      if (!active) begin
        if (go) begin
          active <= 1'b1;
          cs_q   <= 1'b0;
          sh     <= tx;
          left   <= len;
          div    <= DIV_INIT;
          first  <= 1'b1;
        end
      end else if (div != '0) begin
        div <= div - 1'b1;
      end else begin
        div <= DIV_INIT;
        if (sclk_q) begin
          if (left == '0) begin
            active <= 1'b0;
            cs_q   <= 1'b1;
            fin_q  <= 1'b1;
          end else begin
            sclk_q <= 1'b0;
            if (!first) sh <= {sh[FRAME_W-2:0], 1'b0};
            first <= 1'b0;
          end
        end else begin
          sclk_q <= 1'b1;
          rx_q   <= {rx_q[RX_W-2:0], miso};
          left   <= left - 1'b1;
        end
      end
    end
  end

  assign sclk = sclk_q;
  assign cs_n = cs_q;
  assign mosi = sh[FRAME_W-1];
  assign rx   = rx_q;
  assign fin  = fin_q;

  // R12: the serial clock only moves inside a selected frame
  p_sclk_framed_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sclk_q) |-> !cs_q);

endmodule

// File: rtl/sdadc_countdown.sv
module sdadc_countdown #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] value,
  output logic         expired
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (load) cnt <= value;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/sdadc_ready_watch.sv
module sdadc_ready_watch #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic line,
  output logic fell
);

  logic line_s;
  logic seen_high;

  generate
    if (SYNC_STAGES < 2) begin : g_single
      logic s_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= 1'b1;
        else s_q <= line;
      end
      assign line_s = s_q;
    end else begin : g_chain
      logic [SYNC_STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else chain <= {chain[SYNC_STAGES-2:0], line};
      end
      assign line_s = chain[SYNC_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_high <= 1'b0;
    else if (arm) seen_high <= 1'b0;
    else if (line_s) seen_high <= 1'b1;
  end

  assign fell = seen_high & ~line_s;

endmodule

// File: rtl/sdadc_bringup_seq.sv
module sdadc_bringup_seq
  import sdadc_seq_pkg::*;
#(
  parameter int unsigned CLK_DIV       = 4,
  parameter int unsigned SETTLE_CYCLES = 50000,
  parameter int unsigned CAL_TIMEOUT   = 2000000,
  parameter int unsigned NUM_CAL_CH    = 3,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [3:0] exp_id,
  input  logic [1:0] clk_sel,
  input  logic [2:0] gain_sel,
  input  logic       buf_on,
  input  logic       exc_on,
  input  logic [1:0] exc_mag,
  input  logic [1:0] exc_route,
  input  logic       miso,
  output logic       sclk,
  output logic       cs_n,
  output logic       mosi,
  output logic       done,
  output logic       busy,
  output logic       err
);

  localparam int unsigned FRAME_W = 32;
  localparam int unsigned LEN_W   = $clog2(FRAME_W + 1);
  localparam int unsigned TMR_MAX = (SETTLE_CYCLES > CAL_TIMEOUT) ? SETTLE_CYCLES : CAL_TIMEOUT;
  localparam int unsigned TMR_W   = $clog2(TMR_MAX + 1);
  localparam int unsigned CH_W    = (NUM_CAL_CH > 1) ? $clog2(NUM_CAL_CH) : 1;
  localparam logic [CH_W-1:0] CH_LAST = CH_W'(NUM_CAL_CH - 1);

  seq_state_e state;
  logic       go_q;
  logic       done_q;
  logic       err_q;
  logic       cal_full;
  logic [CH_W-1:0] ch;

  // events between the pieces
  logic               xfer_fin;
  logic [3:0]         id_nib;
  logic               eng_cs_n;
  logic [FRAME_W-1:0] tx_frame;
  logic [LEN_W-1:0]   tx_len;
  logic               tmr_load;
  logic [TMR_W-1:0]   tmr_value;
  logic               tmr_expired;
  logic               rdy_arm;
  logic               rdy_fell;
  logic               in_wait;

  always_comb begin
    tx_frame = '0;
    tx_len   = '0;
    case (state)
      S_RST: begin
        tx_frame = '1;
        tx_len   = LEN_W'(32);
      end
      S_ID: begin
        tx_frame = {cmd_byte(1'b1, REG_ID), 24'h0};
        tx_len   = LEN_W'(16);
      end
      S_MODE: begin
        tx_frame = {cmd_byte(1'b0, REG_MODE), mode_word(OPM_IDLE, clk_sel, RATE_BOOT), 8'h0};
        tx_len   = LEN_W'(24);
      end
      S_CONF, S_SEL: begin
        tx_frame = {cmd_byte(1'b0, REG_CONF), conf_word(gain_sel, buf_on, 4'(ch)), 8'h0};
        tx_len   = LEN_W'(24);
      end
      S_IO: begin
        tx_frame = {cmd_byte(1'b0, REG_IO), io_byte(exc_mag, exc_route), 16'h0};
        tx_len   = LEN_W'(16);
      end
      S_CAL: begin
        tx_frame = {cmd_byte(1'b0, REG_MODE),
                    mode_word(cal_full ? OPM_FULL_CAL : OPM_ZERO_CAL, clk_sel, RATE_BOOT), 8'h0};
        tx_len   = LEN_W'(24);
      end
      default: begin
        tx_frame = '0;
        tx_len   = '0;
      end
    endcase
  end

  assign tmr_load  = xfer_fin && (state == S_RST || state == S_CAL);
  assign tmr_value = (state == S_RST) ? TMR_W'(SETTLE_CYCLES) : TMR_W'(CAL_TIMEOUT);
  assign rdy_arm   = xfer_fin && (state == S_CAL);
  assign in_wait   = (state == S_CAL_WAIT);

  sdadc_spi_shifter #(
    .CLK_DIV(CLK_DIV),
    .FRAME_W(FRAME_W),
    .RX_W   (4)
  ) i_shifter (
    .clk  (clk),
    .rst_n(rst_n),
    .go   (go_q),
    .len  (tx_len),
    .tx   (tx_frame),
    .miso (miso),
    .rx   (id_nib),
    .fin  (xfer_fin),
    .sclk (sclk),
    .cs_n (eng_cs_n),
    .mosi (mosi)
  );

  sdadc_countdown #(.W(TMR_W)) i_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (tmr_load),
    .value  (tmr_value),
    .expired(tmr_expired)
  );

  sdadc_ready_watch #(.SYNC_STAGES(SYNC_STAGES)) i_ready (
    .clk  (clk),
    .rst_n(rst_n),
    .arm  (rdy_arm),
    .line (miso),
    .fell (rdy_fell)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      go_q     <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      cal_full <= 1'b0;
      ch       <= '0;
    end else begin
      go_q   <= 1'b0;
      done_q <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          state    <= S_RST;
          go_q     <= 1'b1;
          ch       <= '0;
          cal_full <= 1'b0;
          err_q    <= 1'b0;
        end
        S_RST: if (xfer_fin) state <= S_SETTLE;
        S_SETTLE: if (tmr_expired) begin
          state <= S_ID;
          go_q  <= 1'b1;
        end
        S_ID: if (xfer_fin) begin
          if (id_nib == exp_id) begin
            state <= S_MODE;
            go_q  <= 1'b1;
          end else begin
            state <= S_FAIL;
          end
        end
        S_MODE: if (xfer_fin) begin
          state <= S_CONF;
          go_q  <= 1'b1;
        end
        S_CONF: if (xfer_fin) begin
          state <= exc_on ? S_IO : S_SEL;
          go_q  <= 1'b1;
        end
        S_IO: if (xfer_fin) begin
          state <= S_SEL;
          go_q  <= 1'b1;
        end
        S_SEL: if (xfer_fin) begin
          state    <= S_CAL;
          go_q     <= 1'b1;
          cal_full <= 1'b0;
        end
        S_CAL: if (xfer_fin) state <= S_CAL_WAIT;
        S_CAL_WAIT: begin
          if (rdy_fell) begin
            if (!cal_full) begin
              cal_full <= 1'b1;
              state    <= S_CAL;
              go_q     <= 1'b1;
            end else if (ch == CH_LAST) begin
              state  <= S_IDLE;
              done_q <= 1'b1;
            end else begin
              ch    <= ch + 1'b1;
              state <= S_SEL;
              go_q  <= 1'b1;
            end
          end else if (tmr_expired) begin
            state <= S_FAIL;
          end
        end
        S_FAIL: begin
          err_q <= 1'b1;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // chip select is also held low while the ready flag is watched
  assign cs_n = eng_cs_n & ~in_wait;
  assign busy = (state != S_IDLE);
  assign done = done_q;
  assign err  = err_q;

  // R1: the reset frame only ever drives ones
  p_reset_mosi_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RST && !cs_n) |-> mosi);

  // R10: a run only ends with an outcome
  p_busy_ends_with_outcome_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done || err));

  // R10: success and failure never coincide
  p_done_err_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));

  // R11: a run is only entered from a start request
  p_busy_needs_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

endmodule

// File: tb/test_sdadc_bringup_seq.sv
module test_sdadc_bringup_seq;

  localparam int CLK_DIV = 2;
  localparam int SETTLE  = 300;
  localparam int TMO     = 500;
  localparam int RDY_DLY = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [3:0] exp_id = 4'hB;
  logic [1:0] clk_sel = 2'd0;
  logic [2:0] gain_sel = 3'd0;
  logic buf_on = 1'b0;
  logic exc_on = 1'b0;
  logic [1:0] exc_mag = 2'd0;
  logic [1:0] exc_route = 2'd0;
  wire  miso;
  logic sclk, cs_n, mosi, done, busy, err;

  always #5 clk = ~clk;

  sdadc_bringup_seq #(
    .CLK_DIV(CLK_DIV), .SETTLE_CYCLES(SETTLE), .CAL_TIMEOUT(TMO),
    .NUM_CAL_CH(3), .SYNC_STAGES(2)
  ) i_sdadc_bringup_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .exp_id(exp_id),
    .clk_sel(clk_sel), .gain_sel(gain_sel), .buf_on(buf_on),
    .exc_on(exc_on), .exc_mag(exc_mag), .exc_route(exc_route),
    .miso(miso), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .done(done), .busy(busy), .err(err)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // run configuration, written only by the stimulus
  int       epoch = 0;
  int       cfg_allow = 0;
  logic [7:0] cfg_dev_id = 8'h00;

  // converter model state, written only by the monitor
  int       seen_epoch = 0;
  int       nb = 0;
  logic [31:0] sh = '0;
  logic [7:0] cmd_q = '0;
  logic     sclk_q = 1'b1, cs_q = 1'b1;
  logic     rd_drive = 1'b0, id_bit = 1'b0, rdy_level = 1'b1;
  int       rdy_cnt = 0;
  bit       rdy_arm = 0;
  int       rdy_allow = 0;
  logic [7:0] dev_id = '0;
  int       fr_n = 0;
  int       fr_len [32];
  logic [31:0] fr_dat [32];
  int       fr_ts [32];
  int       fr_te [32];
  int       t_fall = 0;
  int       done_cnt = 0;

  assign miso = rd_drive ? id_bit : rdy_level;

  always @(negedge clk) begin
    if (epoch != seen_epoch) begin
      seen_epoch = epoch;
      fr_n = 0;
      done_cnt = 0;
      rdy_allow = cfg_allow;
      dev_id = cfg_dev_id;
    end
    if (done) done_cnt++;
    if (!cs_n && cs_q) t_fall = cyc;
    if (!cs_n && sclk && !sclk_q) begin
      if (nb == 7) cmd_q = {sh[6:0], mosi};
      sh = {sh[30:0], mosi};
      nb++;
    end
    if (!cs_n && !sclk && sclk_q && nb >= 8 && nb < 16 && cmd_q[7:6] == 2'b01) begin
      rd_drive = 1'b1;
      id_bit = dev_id[7 - (nb - 8)];
    end
    if (cs_n && !cs_q) begin
      if (nb > 0 && fr_n < 32) begin
        fr_len[fr_n] = nb;
        fr_dat[fr_n] = sh;
        fr_ts[fr_n] = t_fall;
        fr_te[fr_n] = cyc;
        fr_n++;
        if (nb == 24 && sh[23:16] == 8'h08 && (sh[15:13] == 3'd4 || sh[15:13] == 3'd5)
            && rdy_allow > 0) begin
          rdy_allow--;
          rdy_arm = 1;
          rdy_cnt = RDY_DLY;
        end
      end
      nb = 0;
      cmd_q = '0;
      rd_drive = 1'b0;
      rdy_level = 1'b1;
    end
    if (rdy_arm) begin
      if (rdy_cnt == 0) begin
        rdy_level = 1'b0;
        rdy_arm = 0;
      end else rdy_cnt--;
    end
    sclk_q = sclk;
    cs_q = cs_n;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // expected words restated as arithmetic
  function automatic logic [31:0] e_mode(input int opm);
    return 32'(8 * 65536 + opm * 8192 + int'(clk_sel) * 64 + 1);
  endfunction
  function automatic logic [31:0] e_conf(input int chan);
    return 32'(16 * 65536 + int'(gain_sel) * 256 + int'(buf_on) * 16 + chan);
  endfunction
  function automatic logic [31:0] e_io();
    return 32'(40 * 256 + int'(exc_route) * 4 + int'(exc_mag));
  endfunction

  task automatic check_frame(input int idx, input int len, input logic [31:0] val,
                             input string req);
    logic [31:0] mask;
    mask = (len == 32) ? 32'hFFFF_FFFF : ((32'h1 << len) - 1);
    check(fr_len[idx] == len, req, $sformatf("frame %0d length", idx), fr_len[idx], len);
    check((fr_dat[idx] & mask) == val, req, $sformatf("frame %0d data", idx),
          fr_dat[idx] & mask, val);
  endtask

  int t_end = 0;

  task automatic run_seq(input logic [7:0] id, input int allow, input int poke);
    int n;
    cfg_dev_id = id;
    cfg_allow = allow;
    epoch++;
    @(negedge clk);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (done_cnt == 0 && !err && n < 60000) begin
      @(negedge clk);
      n++;
      start = (n == poke);
    end
    start = 1'b0;
    t_end = cyc;
    repeat (20) @(negedge clk);
  endtask

  task automatic t_reset_state();
    check(busy == 1'b0, "R10", "busy after reset", busy, 0);
    check(done == 1'b0 && err == 1'b0, "R10", "done/err after reset", {done, err}, 0);
    check(cs_n == 1'b1 && sclk == 1'b1, "R12", "idle cs_n/sclk", {cs_n, sclk}, 2'b11);
  endtask

  task automatic t_full_with_exc();
    clk_sel = 2'd2; gain_sel = 3'd5; buf_on = 1'b1;
    exc_on = 1'b1; exc_mag = 2'd3; exc_route = 2'd1; exp_id = 4'hB;
    run_seq(8'h0B, 6, 200);
    check(done_cnt == 1, "R11", "done pulses with extra start", done_cnt, 1);
    check(err == 1'b0, "R10", "err on success", err, 0);
    check(busy == 1'b0, "R10", "busy after done", busy, 0);
    check(fr_n == 14, "R8", "frame count", fr_n, 14);
    check_frame(0, 32, 32'hFFFF_FFFF, "R1");
    check(fr_ts[1] - fr_te[0] >= SETTLE, "R2", "settle gap", fr_ts[1] - fr_te[0], SETTLE);
    check_frame(1, 16, 32'h6000, "R4");
    check_frame(2, 24, e_mode(2), "R5");
    check_frame(3, 24, e_conf(0), "R6");
    check_frame(4, 16, e_io(), "R7");
    for (int c = 0; c < 3; c++) begin
      check_frame(5 + 3 * c, 24, e_conf(c), "R8");
      check_frame(6 + 3 * c, 24, e_mode(4), "R8");
      check_frame(7 + 3 * c, 24, e_mode(5), "R8");
    end
    for (int i = 1; i < 14; i++) begin
      logic [7:0] cb;
      cb = 8'(fr_dat[i] >> (fr_len[i] - 8));
      check(cb[7] == 1'b0 && cb[2:0] == 3'b000, "R3", $sformatf("command byte %0d", i), cb, cb & 8'h78);
    end
    check(sclk == 1'b1 && cs_n == 1'b1, "R12", "idle after run", {sclk, cs_n}, 2'b11);
  endtask

  task automatic t_no_exc_high_nibble();
    clk_sel = 2'd1; gain_sel = 3'd2; buf_on = 1'b0; exc_on = 1'b0; exp_id = 4'hB;
    run_seq(8'h5B, 6, 0);
    check(done_cnt == 1 && err == 1'b0, "R4", "upper nibble ignored", {done_cnt[0], err}, 2'b10);
    check(fr_n == 13, "R7", "frame count without excitation", fr_n, 13);
    check_frame(2, 24, e_mode(2), "R5");
    check_frame(4, 24, e_conf(0), "R7");
  endtask

  task automatic t_id_mismatch();
    exp_id = 4'hB;
    run_seq(8'h0A, 6, 0);
    check(err == 1'b1, "R4", "err on id mismatch", err, 1);
    check(done_cnt == 0, "R4", "no done on mismatch", done_cnt, 0);
    check(fr_n == 2, "R4", "frames after mismatch", fr_n, 2);
    repeat (40) @(negedge clk);
    check(err == 1'b1 && busy == 1'b0, "R13", "err held", {err, busy}, 2'b10);
  endtask

  task automatic t_timeout();
    exc_on = 1'b0; exp_id = 4'hB;
    run_seq(8'h0B, 3, 0);
    check(err == 1'b1, "R9", "err on timeout", err, 1);
    check(done_cnt == 0, "R9", "no done on timeout", done_cnt, 0);
    check(fr_n == 10, "R9", "frames at timeout", fr_n, 10);
    check(t_end - fr_te[9] >= TMO, "R9", "timeout length", t_end - fr_te[9], TMO);
  endtask

  task automatic t_recovery();
    check(err == 1'b1, "R13", "err held before restart", err, 1);
    run_seq(8'h0B, 6, 0);
    check(err == 1'b0 && done_cnt == 1, "R13", "restart clears err", {err, done_cnt[0]}, 2'b01);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset_state();
    t_full_with_exc();
    t_no_exc_high_nibble();
    t_id_mismatch();
    t_timeout();
    t_recovery();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures + 1);
    $finish;
  end

endmodule